// File: doc/BRIEF.md
# Double-Buffered DMA Channel Controller

This block is the control state machine for a single DMA channel that moves data between a peripheral and memory. It holds two buffer descriptors and uses them in turn. While the channel works through one buffer, software can fill in the other one. When the active buffer runs out, the channel moves straight on to the queued one without a gap, and it tells software that the old descriptor can be rewritten.

Each descriptor is modelled as a remaining-count register. A base write loads the count, and each transfer beat lowers it by one. The buffer counts as expired when the active count is zero. Peripheral errors have three possible outcomes, chosen by two control bits:

- the error ends the current buffer;
- the error aborts the channel to the stalled state;
- the error is ignored.

The controller has four states: idle, stalled, running, and running with a queued buffer. The state itself is not a port. The bench and the checker see it through the transfer enable, the descriptor select, the active count and the two interrupt pulses.

Top module: `dmach_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `xfer_en`, `desc_sel`, `stall_irq`, `nfb_irq` and both descriptor counts are zero, and the channel is idle.
- R2: If `chan_en` is low at a clock edge, the channel is idle after that edge from any state: `xfer_en` is 0, `desc_sel` is 0 and no interrupt pulses. Base writes while idle load nothing.
- R3: Raising `chan_en` while idle enters the stalled state. `xfer_en` stays 0 and `stall_irq` is not raised.
- R4: In the stalled state no transfer runs, and `beat` leaves the counts unchanged. A base write loads `base_cnt` into the descriptor chosen by `desc_sel` and starts the transfer, so `xfer_en` is 1 after that edge.
- R5: While running, an active count of zero moves the channel to the stalled state and raises `stall_irq` for exactly one cycle.
- R6: While running with no queued buffer, `periph_err` with `ign_err` clear clears the active count and stalls the channel without `stall_irq`.
- R7: While running, a base write loads the other descriptor and queues it. Transfers continue on the active descriptor, and `desc_sel` is unchanged.
- R8: With a buffer queued, an active count of zero, or `periph_err` with both `ign_err` and `abort_en` clear, clears the old count, toggles `desc_sel`, keeps the transfer running and raises `nfb_irq` for one cycle.
- R9: With a buffer queued, `periph_err` with `abort_en` set and `ign_err` clear clears the active count and stalls the channel without any interrupt.
- R10: With `ign_err` set, `periph_err` has no effect in either running state.
- R11: While `xfer_en` is 1, each `beat` lowers the active count by one, stopping at zero. `act_cnt` always shows the count of the descriptor selected by `desc_sel`.
- R12: `stall_irq` and `nfb_irq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable control bit |
| ign_err | input | 1 | Ignore peripheral errors |
| abort_en | input | 1 | Abort to stall on error while a buffer is queued |
| base_wr | input | 1 | Base-address register write strobe |
| base_cnt | input | CNT_W | Byte count loaded by a base write |
| beat | input | 1 | One transfer beat completed |
| periph_err | input | 1 | Peripheral end/error indication |
| xfer_en | output | 1 | Transfers may run |
| desc_sel | output | 1 | Active descriptor index |
| stall_irq | output | 1 | Stall interrupt pulse |
| nfb_irq | output | 1 | Next-buffer interrupt pulse |
| act_cnt | output | CNT_W | Remaining count of the active descriptor |

## Verification
The state machine is driven through three ways of ending a buffer: a count that runs down to zero, a peripheral error, and an aborting error. Each is tried both with and without a queued descriptor. A buffer ended by its count and one ended by an error give different select and interrupt results, so the two mechanisms can be told apart. Repeating the same error stimulus with `ign_err` set, and again with `abort_en` set, separates the ignore, end-buffer and abort paths. Base writes and beats in the idle and stalled states, plus a disable while a buffer is queued, show that nothing moves outside the running states.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int NDESC = 2;
    localparam int SEL_W = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_ON    = 2'd2,
        ST_NEXT  = 2'd3
    } chan_st_t;

    typedef struct packed {
        logic [NDESC-1:0] load;
        logic [NDESC-1:0] clr;
        logic [NDESC-1:0] dec;
    } desc_ctl_t;

    function automatic logic st_moving(chan_st_t st);
        return (st == ST_ON) || (st == ST_NEXT);
    endfunction

endpackage

// File: rtl/dmach_desc.sv
module dmach_desc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clr,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             ign_err,
    input  logic             abort_en,
    input  logic             base_wr,
    input  logic             beat,
    input  logic             periph_err,
    input  logic             expired,
    output chan_st_t         state,
    output logic [SEL_W-1:0] sel,
    output logic             stall_irq,
    output logic             nfb_irq,
    output desc_ctl_t        ctl
);
    chan_st_t         state_n;
    logic [SEL_W-1:0] sel_n;
    logic [SEL_W-1:0] oth;
    logic             stall_p;
    logic             nfb_p;
    logic             err_live;

    assign oth      = ~sel;
    assign err_live = periph_err && !ign_err;

    always_comb begin
        state_n = state;
        sel_n   = sel;
        stall_p = 1'b0;
        nfb_p   = 1'b0;
        ctl     = '0;
        unique case (state)
            ST_IDLE: state_n = ST_STALL;
            ST_STALL: begin
                if (base_wr) begin
                    state_n       = ST_ON;
                    ctl.load[sel] = 1'b1;
                end
            end
            ST_ON: begin
                if (expired) begin
                    state_n = ST_STALL;
                    stall_p = 1'b1;
                end else if (err_live) begin
                    state_n      = ST_STALL;
                    ctl.clr[sel] = 1'b1;
                end else begin
                    if (base_wr) begin
                        state_n       = ST_NEXT;
                        ctl.load[oth] = 1'b1;
                    end
                    ctl.dec[sel] = beat;
                end
            end
            ST_NEXT: begin
                if (err_live && abort_en) begin
                    state_n      = ST_STALL;
                    ctl.clr[sel] = 1'b1;
                end else if (expired || err_live) begin
                    state_n      = ST_ON;
                    sel_n        = oth;
                    nfb_p        = 1'b1;
                    ctl.clr[sel] = 1'b1;
                end else begin
                    ctl.load[oth] = base_wr;
                    ctl.dec[sel]  = beat;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (!chan_en) begin
            state_n = ST_IDLE;
            sel_n   = '0;
            stall_p = 1'b0;
            nfb_p   = 1'b0;
            ctl     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sel       <= '0;
            stall_irq <= 1'b0;
            nfb_irq   <= 1'b0;
        end else begin
            state     <= state_n;
            sel       <= sel_n;
            stall_irq <= stall_p;
            nfb_irq   <= nfb_p;
        end
    end
endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             ign_err,
    input  logic             abort_en,
    input  logic             base_wr,
    input  logic [CNT_W-1:0] base_cnt,
    input  logic             beat,
    input  logic             periph_err,
    output logic             xfer_en,
    output logic             desc_sel,
    output logic             stall_irq,
    output logic             nfb_irq,
    output logic [CNT_W-1:0] act_cnt
);
    chan_st_t         state;
    logic [SEL_W-1:0] sel;
    desc_ctl_t        ctl;
    logic [CNT_W-1:0] cnt_arr [NDESC];
    logic             expired;

    dmach_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .ign_err    (ign_err),
        .abort_en   (abort_en),
        .base_wr    (base_wr),
        .beat       (beat),
        .periph_err (periph_err),
        .expired    (expired),
        .state      (state),
        .sel        (sel),
        .stall_irq  (stall_irq),
        .nfb_irq    (nfb_irq),
        .ctl        (ctl)
    );

    for (genvar g = 0; g < NDESC; g++) begin : g_desc
        dmach_desc #(.CNT_W(CNT_W)) u_desc (
            .clk      (clk),
            .rst      (rst),
            .load     (ctl.load[g]),
            .clr      (ctl.clr[g]),
            .dec      (ctl.dec[g]),
            .load_val (base_cnt),
            .cnt      (cnt_arr[g])
        );
    end

    assign act_cnt  = cnt_arr[sel];
    assign expired  = (act_cnt == '0);
    assign xfer_en  = st_moving(state);
    assign desc_sel = sel[0];
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_en,
    input logic             beat,
    input logic             periph_err,
    input logic             xfer_en,
    input logic             desc_sel,
    input logic             stall_irq,
    input logic             nfb_irq,
    input logic [CNT_W-1:0] act_cnt
);
    assert_disable_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (!xfer_en && !desc_sel && !stall_irq && !nfb_irq));

    assert_enable_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!xfer_en && $rose(chan_en)) |=> (!stall_irq && !xfer_en));

    assert_stall_after_run_R5: assert property (@(posedge clk) disable iff (rst)
        stall_irq |-> (!xfer_en && $past(xfer_en)));

    assert_nfb_switch_R8: assert property (@(posedge clk) disable iff (rst)
        nfb_irq |-> (xfer_en && desc_sel != $past(desc_sel)));

    assert_beat_count_R11: assert property (@(posedge clk) disable iff (rst)
        (chan_en && xfer_en && beat && !periph_err && act_cnt != '0 && !nfb_irq)
        |=> (act_cnt == $past(act_cnt) - 1'b1) || nfb_irq);

    assert_irq_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stall_irq, nfb_irq}));
endmodule

bind dmach_top dmach_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .beat       (beat),
    .periph_err (periph_err),
    .xfer_en    (xfer_en),
    .desc_sel   (desc_sel),
    .stall_irq  (stall_irq),
    .nfb_irq    (nfb_irq),
    .act_cnt    (act_cnt)
);

// File: tb/tb_dmach_top.sv
module tb_dmach_top;
    localparam int CW = 8;

    typedef struct packed {
        logic          en;
        logic          ign;
        logic          ab;
        logic          wr;
        logic [CW-1:0] val;
        logic          bt;
        logic          er;
        logic          xf;
        logic          sl;
        logic          st;
        logic          nf;
        logic [CW-1:0] cnt;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 28;
    // en ign ab wr val bt er | xf sl st nf cnt | req
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,8'd0,0,0, 0,0,0,0,8'd0, 4'd3},  // R3 enable -> stall
        '{1,0,0,1,8'd3,0,0, 1,0,0,0,8'd3, 4'd4},  // R4 base write starts
        '{1,0,0,0,8'd0,1,0, 1,0,0,0,8'd2, 4'd11}, // R11
        '{1,0,0,0,8'd0,1,0, 1,0,0,0,8'd1, 4'd11},
        '{1,0,0,0,8'd0,1,0, 1,0,0,0,8'd0, 4'd11},
        '{1,0,0,0,8'd0,0,0, 0,0,1,0,8'd0, 4'd5},  // R5 expiry stall irq
        '{1,0,0,0,8'd0,0,0, 0,0,0,0,8'd0, 4'd12}, // R12 single pulse
        '{1,0,0,0,8'd0,1,0, 0,0,0,0,8'd0, 4'd4},  // R4 beat ignored
        '{1,0,0,1,8'd5,0,0, 1,0,0,0,8'd5, 4'd4},
        '{1,0,0,1,8'd2,0,0, 1,0,0,0,8'd5, 4'd7},  // R7 queue buffer
        '{1,0,0,0,8'd0,1,0, 1,0,0,0,8'd4, 4'd7},
        '{1,0,0,0,8'd0,0,1, 1,1,0,1,8'd2, 4'd8},  // R8 error switch
        '{1,0,0,0,8'd0,1,0, 1,1,0,0,8'd1, 4'd8},
        '{1,1,0,0,8'd0,0,1, 1,1,0,0,8'd1, 4'd10}, // R10 ignored in ON
        '{1,0,0,1,8'd4,0,0, 1,1,0,0,8'd1, 4'd7},
        '{1,0,0,0,8'd0,1,0, 1,1,0,0,8'd0, 4'd11},
        '{1,0,0,0,8'd0,0,0, 1,0,0,1,8'd4, 4'd8},  // R8 expiry switch
        '{1,0,0,1,8'd6,0,0, 1,0,0,0,8'd4, 4'd7},
        '{1,0,1,0,8'd0,0,1, 0,0,0,0,8'd0, 4'd9},  // R9 abort
        '{1,0,0,1,8'd2,0,0, 1,0,0,0,8'd2, 4'd4},
        '{1,0,0,0,8'd0,0,1, 0,0,0,0,8'd0, 4'd6},  // R6 error in ON
        '{1,0,0,1,8'd3,0,0, 1,0,0,0,8'd3, 4'd4},
        '{1,0,0,1,8'd7,0,0, 1,0,0,0,8'd3, 4'd7},
        '{1,1,1,0,8'd0,1,1, 1,0,0,0,8'd2, 4'd10}, // R10 ignored in NEXT
        '{1,0,0,0,8'd0,0,1, 1,1,0,1,8'd7, 4'd8},
        '{0,0,0,0,8'd0,0,0, 0,0,0,0,8'd0, 4'd2},  // R2 disable
        '{0,0,0,1,8'd9,0,0, 0,0,0,0,8'd0, 4'd2},  // R2 write ignored
        '{1,0,0,0,8'd0,0,0, 0,0,0,0,8'd0, 4'd3}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          chan_en, ign_err, abort_en, base_wr, beat, periph_err;
    logic [CW-1:0] base_cnt;
    logic          xfer_en, desc_sel, stall_irq, nfb_irq;
    logic [CW-1:0] act_cnt;
    int            n_chk = 0;
    int            n_bad = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    dmach_top #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .ign_err(ign_err),
        .abort_en(abort_en), .base_wr(base_wr), .base_cnt(base_cnt),
        .beat(beat), .periph_err(periph_err), .xfer_en(xfer_en),
        .desc_sel(desc_sel), .stall_irq(stall_irq), .nfb_irq(nfb_irq),
        .act_cnt(act_cnt)
    );

    task automatic drive(input logic en, ign, ab, wr, input logic [CW-1:0] v,
                         input logic bt, er);
        chan_en = en; ign_err = ign; abort_en = ab; base_wr = wr;
        base_cnt = v; beat = bt; periph_err = er;
    endtask

    task automatic check(input int req, input logic xf, sl, st, nf,
                         input logic [CW-1:0] cnt);
        logic [CW+3:0] got, exp;
        got = {xfer_en, desc_sel, stall_irq, nfb_irq, act_cnt};
        exp = {xf, sl, st, nf, cnt};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d xf/sl/st/nf/cnt actual %b %b %b %b %0d expected %b %b %b %b %0d",
                     req, xfer_en, desc_sel, stall_irq, nfb_irq, act_cnt,
                     xf, sl, st, nf, cnt);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, '0, 0, 0);
        repeat (2) @(negedge clk);
        check(1, 0, 0, 0, 0, 8'd0);  // R1 reset state
        rst = 1'b0;
        @(negedge clk);
        check(1, 0, 0, 0, 0, 8'd0);  // R1 first cycle after reset

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].en, VEC[i].ign, VEC[i].ab, VEC[i].wr, VEC[i].val,
                  VEC[i].bt, VEC[i].er);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].xf, VEC[i].sl, VEC[i].st,
                  VEC[i].nf, VEC[i].cnt);
        end

        // R2: disable while a buffer is queued
        drive(1, 0, 0, 1, 8'd5, 0, 0); @(negedge clk);
        drive(1, 0, 0, 1, 8'd3, 0, 0); @(negedge clk);
        check(7, 1, 0, 0, 0, 8'd5);
        drive(0, 0, 0, 0, 8'd0, 0, 0); @(negedge clk);
        check(2, 0, 0, 0, 0, 8'd5);

        // R1: reset in the middle of a run clears counts
        drive(1, 0, 0, 0, 8'd0, 0, 0); @(negedge clk);
        drive(1, 0, 0, 1, 8'd6, 0, 0); @(negedge clk);
        check(4, 1, 0, 0, 0, 8'd6);
        drive(1, 0, 0, 0, 8'd0, 0, 0);
        rst = 1'b1; @(negedge clk);
        check(1, 0, 0, 0, 0, 8'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule